// File: doc/BRIEF.md
# Dual-Source Video Capture Multiplexer

This block takes pixels from two cameras' worth of input: words from a 10-bit video converter and pixels from a 14-bit digital camera port. It puts one stream onto a 14-bit processor data bus. A free-running counter divides the fast reference clock by four. The divided clock is sent out as the pixel sampling clock, and the same counter gives an internal strobe at which every input is registered. Separated line and field sync inputs are edge-detected to find line and frame starts. Each start raises a one-pixel-period interrupt pulse, so the processor can begin a DMA or software read at the right pixel.

The source choice is read once, at the first active pixel of a frame, and is kept until the next frame, so a frame never mixes sources. A converter pixel keeps only its top 8 bits and is zero-extended to the bus width. The bus goes to high impedance while a boot memory is selected on the same wires. A work-enable input stops capture and cancels a pending frame start.

The output is a stream with a valid flag and no ready. The processor cannot push back. Each pixel stays on the bus for exactly one pixel period and is lost if it is not taken. The consumer must therefore keep up with the pixel rate.

Top module: `vidcap_mux`

## Requirements
- R1: `pix_clk` has a period of four reference clocks and is high for two of them. Registered outputs change only once per pixel period, on the reference edge where `pix_clk` falls.
- R2: In analog mode (mode bit 0), the bus carries `ana_word[9:2]` in bits 7:0, and bits 13:8 are zero.
- R3: In digital mode (mode bit 1), the bus carries `dig_word[13:0]` unchanged.
- R4: `mode_dig` is sampled only at the first active pixel of a frame. Changes to it at any other time have no effect on the source until the next frame start.
- R5: A sample is active when `work_en` is 1 and `hsync` is 0. An active sample appears on the bus with `pix_valid` high for the following pixel period.
- R6: `line_irq` is high for one pixel period, together with the first active pixel after `hsync` goes from 1 to 0.
- R7: `frame_irq` is high for one pixel period, together with the `line_irq` of the first line start after a rising edge of `vsync`. Later line starts in the frame do not raise it.
- R8: `line_err` is high alongside every active pixel beyond the 320th pixel of a line.
- R9: While `boot_sel` is 1, the block does not drive `pix_bus`.
- R10: While `work_en` is 0, `pix_valid`, `line_irq` and `frame_irq` stay low. A frame start that is waiting for its first line is cancelled.
- R11: After reset, `pix_valid`, `line_irq`, `frame_irq` and `line_err` are 0, the bus carries zero, and the source is analog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock (nominally four times the pixel rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| work_en | input | 1 | Capture enable |
| mode_dig | input | 1 | Source request: 1 digital camera, 0 converter |
| boot_sel | input | 1 | Boot memory owns the bus; output floats |
| hsync | input | 1 | Separated line sync, high during blanking |
| vsync | input | 1 | Separated field sync, rising edge marks a new frame |
| ana_word | input | 10 | Converter word |
| dig_word | input | 14 | Digital camera pixel |
| pix_clk | output | 1 | Divided pixel sampling clock |
| pix_valid | output | 1 | Bus holds an active pixel this period |
| pix_bus | inout | 14 | Tri-state processor data bus |
| frame_irq | output | 1 | Frame-start interrupt pulse |
| line_irq | output | 1 | Line-start interrupt pulse |
| line_err | output | 1 | Line longer than 320 pixels |

## Verification
The bench toggles `mode_dig` in the middle of frames. A design that samples the mode on every pixel would put the wrong source's bits on the bus. It drives a 322-pixel line and expects exactly two `line_err` pulses; an off-by-one counter gives one pulse or three. It drops `work_en` between a `vsync` edge and the next line start. A design that keeps the frame start armed would fire `frame_irq` late, on a line that is not the first. Finally, a bench driver places its own data on the bus under `boot_sel`. A block that does not release the bus corrupts the value that is read back.

// File: rtl/vidcap_pkg.sv
package vidcap_pkg;
  typedef enum logic {SRC_ANA = 1'b0, SRC_DIG = 1'b1} src_e;

  function automatic src_e src_of(input logic bit_in);
    return bit_in ? SRC_DIG : SRC_ANA;
  endfunction
endpackage

// File: rtl/vidcap_clkdiv.sv
module vidcap_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic stb,
  output logic pix_clk
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign stb     = (cnt == LAST);
  assign pix_clk = (cnt >= HALF);

  // R1
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
  // R1
  stb_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> pix_clk);
endmodule

// File: rtl/vidcap_sync.sv
module vidcap_sync #(
  parameter int LINE_PIX = 320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic work_en,
  input  logic hsync,
  input  logic vsync,
  output logic act,
  output logic frame_st,
  output logic line_irq,
  output logic frame_irq,
  output logic line_err
);
  localparam int CW = $clog2(LINE_PIX + 1);
  localparam logic [CW-1:0] FULL = CW'(LINE_PIX);

  logic          hs_d, vs_d, armed;
  logic [CW-1:0] col;
  logic          line_st, over, vs_rise;

  assign act      = stb && work_en && !hsync;
  assign line_st  = act && hs_d;
  assign frame_st = line_st && armed;
  assign over     = act && !line_st && (col == FULL);
  assign vs_rise  = vsync && !vs_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_d      <= 1'b0;
      vs_d      <= 1'b0;
      armed     <= 1'b0;
      col       <= '0;
      line_irq  <= 1'b0;
      frame_irq <= 1'b0;
      line_err  <= 1'b0;
    end else if (stb) begin
      hs_d      <= hsync;
      vs_d      <= vsync;
      line_irq  <= line_st;
      frame_irq <= frame_st;
      line_err  <= over;
      if (!work_en)      armed <= 1'b0;
      else if (vs_rise)  armed <= 1'b1;
      else if (frame_st) armed <= 1'b0;
      if (line_st)                 col <= CW'(1);
      else if (act && col != FULL) col <= col + 1'b1;
    end
  end

  // R7
  frame_has_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> line_irq);
  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |-> !line_irq);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !work_en) |=> (!line_irq && !frame_irq && !armed));
endmodule

// File: rtl/vidcap_sel.sv
module vidcap_sel
  import vidcap_pkg::*;
#(
  parameter int ANA_W  = 10,
  parameter int ANA_KP = 8,
  parameter int BUS_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             act,
  input  logic             frame_st,
  input  logic             mode_dig,
  input  logic [ANA_W-1:0] ana_word,
  input  logic [BUS_W-1:0] dig_word,
  output logic [BUS_W-1:0] data_q,
  output logic             valid_q
);
  localparam int PAD = BUS_W - ANA_KP;

  src_e             mode_q, cur;
  logic [BUS_W-1:0] ana_ext;

  assign cur = frame_st ? src_of(mode_dig) : mode_q;

  generate
    if (PAD > 0) begin : g_pad
      assign ana_ext = {{PAD{1'b0}}, ana_word[ANA_W-1 -: ANA_KP]};
    end else begin : g_nopad
      assign ana_ext = ana_word[ANA_W-1 -: BUS_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= SRC_ANA;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (stb) begin
      mode_q  <= cur;
      data_q  <= (cur == SRC_DIG) ? dig_word : ana_ext;
      valid_q <= act;
    end
  end

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb && frame_st) |=> $stable(mode_q));
  // R5
  valid_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(valid_q));
endmodule

// File: rtl/vidcap_mux.sv
module vidcap_mux #(
  parameter int DIV      = 4,
  parameter int LINE_PIX = 320,
  parameter int ANA_W    = 10,
  parameter int ANA_KP   = 8,
  parameter int BUS_W    = 14
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             work_en,
  input  logic             mode_dig,
  input  logic             boot_sel,
  input  logic             hsync,
  input  logic             vsync,
  input  logic [ANA_W-1:0] ana_word,
  input  logic [BUS_W-1:0] dig_word,
  output logic             pix_clk,
  output logic             pix_valid,
  inout  wire  [BUS_W-1:0] pix_bus,
  output logic             frame_irq,
  output logic             line_irq,
  output logic             line_err
);
  logic             stb, act, frame_st;
  logic [BUS_W-1:0] data_q;

  vidcap_clkdiv #(.DIV(DIV)) u_div (
    .clk(clk_ref), .rst_n(rst_n), .stb(stb), .pix_clk(pix_clk)
  );

  vidcap_sync #(.LINE_PIX(LINE_PIX)) u_sync (
    .clk(clk_ref), .rst_n(rst_n), .stb(stb), .work_en(work_en),
    .hsync(hsync), .vsync(vsync), .act(act), .frame_st(frame_st),
    .line_irq(line_irq), .frame_irq(frame_irq), .line_err(line_err)
  );

  vidcap_sel #(.ANA_W(ANA_W), .ANA_KP(ANA_KP), .BUS_W(BUS_W)) u_sel (
    .clk(clk_ref), .rst_n(rst_n), .stb(stb), .act(act),
    .frame_st(frame_st), .mode_dig(mode_dig), .ana_word(ana_word),
    .dig_word(dig_word), .data_q(data_q), .valid_q(pix_valid)
  );

  assign pix_bus = boot_sel ? {BUS_W{1'bz}} : data_q;
endmodule

// File: tb/test_vidcap_mux.sv
module test_vidcap_mux;
  localparam int CLK_NS = 8;
  localparam int LPIX   = 320;

  logic clk_ref = 1'b0;
  always #(CLK_NS / 2) clk_ref = ~clk_ref;

  logic        rst_n = 1'b0, work_en = 1'b0, mode_dig = 1'b0, boot_sel = 1'b0;
  logic        hsync = 1'b1, vsync = 1'b0;
  logic [9:0]  ana_word = '0;
  logic [13:0] dig_word = '0, boot_data = '0;
  logic        pix_clk, pix_valid, frame_irq, line_irq, line_err;
  wire  [13:0] pix_bus;

  assign pix_bus = boot_sel ? boot_data : 14'bz;

  vidcap_mux i_vidcap_mux (
    .clk_ref(clk_ref), .rst_n(rst_n), .work_en(work_en), .mode_dig(mode_dig),
    .boot_sel(boot_sel), .hsync(hsync), .vsync(vsync), .ana_word(ana_word),
    .dig_word(dig_word), .pix_clk(pix_clk), .pix_valid(pix_valid),
    .pix_bus(pix_bus), .frame_irq(frame_irq), .line_irq(line_irq),
    .line_err(line_err)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  bit          m_hs = 0, m_vs = 0, m_armed = 0, m_mode = 0;
  int          m_col = 0;
  bit          e_known = 0, e_valid, e_line, e_frame, e_err, e_dig, e_held, e_idle;
  logic [13:0] e_data;

  task automatic chk(bit ok, string req, string what, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  function automatic logic [13:0] expect_pix(bit dig, logic [9:0] a, logic [13:0] d);
    return dig ? d : {6'd0, a[9:2]};
  endfunction

  task automatic step(bit hs, bit vs, bit md, bit we, bit bs);
    bit act, ls, fs, mode;
    @(posedge pix_clk); #1;
    if (e_known) begin
      chk(pix_valid == e_valid, e_idle ? "R10" : "R5", "pix_valid", pix_valid, e_valid);
      chk(line_irq == e_line, "R6", "line_irq", line_irq, e_line);
      chk(frame_irq == e_frame, "R7", "frame_irq", frame_irq, e_frame);
      chk(line_err == e_err, "R8", "line_err", line_err, e_err);
      if (boot_sel)
        chk(pix_bus == boot_data, "R9", "bus under boot", pix_bus, boot_data);
      else if (e_valid)
        chk(pix_bus == e_data, e_held ? "R4" : (e_dig ? "R3" : "R2"),
            "pixel", pix_bus, e_data);
    end
    hsync = hs; vsync = vs; mode_dig = md; work_en = we; boot_sel = bs;
    ana_word = 10'($urandom); dig_word = 14'($urandom); boot_data = 14'($urandom);
    act  = we && !hs;
    ls   = act && m_hs;
    fs   = ls && m_armed;
    mode = fs ? md : m_mode;
    e_valid = act; e_line = ls; e_frame = fs; e_idle = !we;
    e_err   = act && !ls && (m_col == LPIX);
    e_dig   = mode; e_held = act && !fs && (md != mode);
    e_data  = expect_pix(mode, ana_word, dig_word);
    m_mode  = mode;
    if (ls) m_col = 1;
    else if (act && m_col < LPIX) m_col++;
    if (!we) m_armed = 0;
    else if (vs && !m_vs) m_armed = 1;
    else if (fs) m_armed = 0;
    m_hs = hs; m_vs = vs;
    e_known = 1;
  endtask

  // policy: 0 analog, 1 digital, 2 random per pixel
  task automatic run_line(int npx, int policy, bit we);
    bit md;
    for (int i = 0; i < 2; i++) step(1, 0, policy == 1, we, 0);
    for (int i = 0; i < npx; i++) begin
      md = (policy == 2) ? 1'($urandom) : (policy == 1);
      step(0, 0, md, we, ($urandom % 8) == 0);
    end
  endtask

  task automatic run_frame(int nlines, int policy);
    step(1, 1, policy == 1, 1, 0);
    step(1, 0, policy == 1, 1, 0);
    for (int l = 0; l < nlines; l++) run_line(10 + ($urandom % 40), policy, 1);
  endtask

  initial begin
    time t0, t1, t2;
    void'($urandom(32'd7031));
    repeat (6) @(posedge clk_ref);
    #1;
    // R11 reset state
    chk(pix_valid == 0, "R11", "valid", pix_valid, 0);
    chk(line_irq == 0 && frame_irq == 0, "R11", "irqs", {line_irq, frame_irq}, 0);
    chk(line_err == 0, "R11", "err", line_err, 0);
    chk(pix_bus == 0, "R11", "bus", pix_bus, 0);
    @(negedge clk_ref); rst_n = 1'b1;
    // R1 divided clock period and duty
    @(posedge pix_clk); t0 = $time;
    @(negedge pix_clk); t2 = $time;
    @(posedge pix_clk); t1 = $time;
    chk((t1 - t0) == 4 * CLK_NS, "R1", "period ns", int'(t1 - t0), 4 * CLK_NS);
    chk((t2 - t0) == 2 * CLK_NS, "R1", "high ns", int'(t2 - t0), 2 * CLK_NS);
    // reset-default analog source before any frame
    run_line(5, 0, 1);
    run_frame(3, 0);
    run_frame(3, 1);
    run_frame(4, 2);                 // R4 mid-frame toggling
    run_line(LPIX + 2, 1, 1);        // R8 two excess pixels
    run_line(LPIX, 0, 1);            // R8 exactly full, no error
    // R10 arm, then drop work_en before first line: no frame irq later
    step(1, 1, 1, 1, 0);
    step(1, 0, 1, 1, 0);
    run_line(8, 1, 0);
    run_line(8, 0, 1);
    for (int f = 0; f < 6; f++) run_frame(1 + ($urandom % 3), $urandom % 3);
    step(1, 0, 0, 1, 0);
    step(1, 0, 0, 1, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      done = 1;
      chk(0, "WATCHDOG", "timeout", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule